// File: doc/BRIEF.md
# Subchannel Engine Binding Router

This block sits between a command stream decoder and a set of execution engines. Each incoming register write carries a method number, a subchannel index, a data word and a count of the parameters still to come in its burst. The router keeps one binding entry per subchannel. Each entry records which engine class currently owns that subchannel. Writes to ordinary methods are steered to the write port of the owning engine.

Two kinds of write never reach an engine. Method zero rebinds its subchannel: the data word becomes that subchannel's engine identifier. The low methods just above zero form a reserved range. The router drops them and flags them as unsupported. A forwarded write whose subchannel holds an identifier that matches no engine is also dropped, and a separate flag reports it.

The input and every engine port use valid/ready. An engine port's valid never waits for its ready. The input's ready follows the ready of the engine port being addressed, so a busy engine stalls the stream and the order of writes is kept. While it is stalled, the upstream source must hold its transaction stable. Writes that are consumed locally (bindings, reserved methods, unknown targets) are accepted in the same cycle, whatever the engine readies are. The two error flags are plain single-cycle pulses that accompany the accepted transaction.

Top module: `subch_router`

## Requirements
- R1: A valid write to method 0 stores the full data word as the engine identifier of its subchannel at the next clock edge. It raises no engine valid and no error flag, and in_ready is 1. A later bind to the same subchannel overwrites the earlier one.
- R2: A valid write with a method from 1 to 63 raises err_reserved and no engine valid. It is accepted with in_ready = 1 even when every engine ready is low.
- R3: A valid write with a method of 64 or above, on a subchannel bound to a known engine, raises exactly that engine's valid bit. It presents in_method and in_data unchanged on eng_method and eng_data.
- R4: The engine identifier codes are 1 = 2D, 2 = 3D, 3 = compute, 4 = DMA copy and 5 = inline-to-memory. They select eng_valid/eng_ready bits 0, 1, 2, 3 and 4 respectively.
- R5: The remaining-parameter count of a forwarded write appears on rem_3d. This output is part of the 3D port only; no other engine port has such an output.
- R6: A forwarded-range write on a subchannel whose identifier is not one of the five codes raises err_unknown and no engine valid, and is accepted at once. The whole data word is compared, so 0x102 is unknown.
- R7: After reset every subchannel holds identifier 0 (invalid), so a forwarded-range write before any bind raises err_unknown.
- R8: While a routed write is waiting, in_ready equals the ready bit of the addressed engine port only. The readies of the other ports have no effect.
- R9: At most one of the engine valid bits, err_reserved and err_unknown is high in any cycle.
- R10: Binding one subchannel leaves the identifiers of all other subchannels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| in_valid | input | 1 | Input write valid |
| in_ready | output | 1 | Input write accepted |
| in_method | input | 13 | Method number |
| in_subch | input | 3 | Subchannel index |
| in_data | input | 32 | Data word / identifier for binds |
| in_remain | input | 8 | Parameters remaining in the burst |
| eng_valid | output | 5 | Per-engine write valid (bit order per R4) |
| eng_ready | input | 5 | Per-engine ready |
| eng_method | output | 13 | Method to the engines |
| eng_data | output | 32 | Data to the engines |
| rem_3d | output | 8 | Remaining count to the 3D engine |
| err_reserved | output | 1 | Reserved method dropped |
| err_unknown | output | 1 | Write to unbound/unknown engine dropped |

## Verification
On every cycle, the assertions check several rules: outcomes are mutually exclusive, binds and reserved methods never reach an engine, forwarded fields pass through unchanged, and the input's ready follows only the addressed port. They cannot see whether the right engine was chosen, because that depends on the bindings stored earlier. The bench scenarios show that: each engine code reaches its own port, a rebind takes effect on the next write, neighbouring subchannels keep their bindings, and the table starts out invalid after reset.

// File: rtl/subch_router_pkg.sv
package subch_router_pkg;
  localparam int unsigned NUM_ENGINES = 5;

  typedef enum logic [1:0] {
    MC_BIND = 2'd0,
    MC_RSVD = 2'd1,
    MC_FWD  = 2'd2
  } mclass_e;

  // Engine port e is selected by identifier e+1.
  function automatic int unsigned engine_code(input int unsigned port);
    return port + 1;
  endfunction
endpackage

// File: rtl/subch_bind_table.sv
module subch_bind_table #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned ID_W    = 32,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ID_W-1:0]  wr_val,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [ID_W-1:0]  rd_val
);
  logic [ID_W-1:0] entry_q [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        entry_q[i] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(i))) begin
        entry_q[i] <= wr_val;
      end
    end
  end

  assign rd_val = entry_q[rd_idx];
endmodule

// File: rtl/subch_classify.sv
module subch_classify
  import subch_router_pkg::*;
#(
  parameter int unsigned METHOD_W   = 13,
  parameter int unsigned ID_W       = 32,
  parameter int unsigned RSVD_LIMIT = 64
) (
  input  logic [METHOD_W-1:0]    method,
  input  logic [ID_W-1:0]        bound_id,
  output mclass_e                cls,
  output logic [NUM_ENGINES-1:0] hit,
  output logic                   known
);
  always_comb begin
    if (method == '0)                          cls = MC_BIND;
    else if (method < METHOD_W'(RSVD_LIMIT))   cls = MC_RSVD;
    else                                       cls = MC_FWD;
  end

  for (genvar e = 0; e < NUM_ENGINES; e++) begin : g_match
    assign hit[e] = (bound_id == ID_W'(engine_code(e)));
  end

  assign known = |hit;
endmodule

// File: rtl/subch_router.sv
module subch_router
  import subch_router_pkg::*;
#(
  parameter int unsigned METHOD_W   = 13,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned REM_W      = 8,
  parameter int unsigned SUBCH_N    = 8,
  parameter int unsigned RSVD_LIMIT = 64,
  localparam int unsigned SUBCH_W   = $clog2(SUBCH_N)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [METHOD_W-1:0]    in_method,
  input  logic [SUBCH_W-1:0]     in_subch,
  input  logic [DATA_W-1:0]      in_data,
  input  logic [REM_W-1:0]       in_remain,
  output logic [NUM_ENGINES-1:0] eng_valid,
  input  logic [NUM_ENGINES-1:0] eng_ready,
  output logic [METHOD_W-1:0]    eng_method,
  output logic [DATA_W-1:0]      eng_data,
  output logic [REM_W-1:0]       rem_3d,
  output logic                   err_reserved,
  output logic                   err_unknown
);
  logic [DATA_W-1:0]      bound_id;
  mclass_e                cls;
  logic [NUM_ENGINES-1:0] hit;
  logic                   known;
  logic                   is_fwd;
  logic                   bind_wr;

  assign bind_wr = in_valid && (cls == MC_BIND);
  assign is_fwd  = in_valid && (cls == MC_FWD);

  subch_bind_table #(
    .ENTRIES (SUBCH_N),
    .ID_W    (DATA_W)
  ) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (bind_wr),
    .wr_idx (in_subch),
    .wr_val (in_data),
    .rd_idx (in_subch),
    .rd_val (bound_id)
  );

  subch_classify #(
    .METHOD_W   (METHOD_W),
    .ID_W       (DATA_W),
    .RSVD_LIMIT (RSVD_LIMIT)
  ) u_classify (
    .method   (in_method),
    .bound_id (bound_id),
    .cls      (cls),
    .hit      (hit),
    .known    (known)
  );

  always_comb begin
    eng_valid = is_fwd ? hit : '0;
    if (cls == MC_FWD && known) in_ready = |(hit & eng_ready);
    else                        in_ready = 1'b1;
  end

  assign err_reserved = in_valid && (cls == MC_RSVD);
  assign err_unknown  = is_fwd && !known;
  assign eng_method   = in_method;
  assign eng_data     = in_data;
  assign rem_3d       = in_remain;
endmodule

// File: rtl/subch_router_chk.sv
module subch_router_chk
  import subch_router_pkg::*;
#(
  parameter int unsigned METHOD_W   = 13,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned REM_W      = 8,
  parameter int unsigned SUBCH_N    = 8,
  parameter int unsigned RSVD_LIMIT = 64,
  localparam int unsigned SUBCH_W   = $clog2(SUBCH_N)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic [METHOD_W-1:0]    in_method,
  input logic [SUBCH_W-1:0]     in_subch,
  input logic [DATA_W-1:0]      in_data,
  input logic [REM_W-1:0]       in_remain,
  input logic [NUM_ENGINES-1:0] eng_valid,
  input logic [NUM_ENGINES-1:0] eng_ready,
  input logic [METHOD_W-1:0]    eng_method,
  input logic [DATA_W-1:0]      eng_data,
  input logic [REM_W-1:0]       rem_3d,
  input logic                   err_reserved,
  input logic                   err_unknown
);
  AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eng_valid, err_reserved, err_unknown})); // R9

  AST_BIND_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_method == '0) |-> (eng_valid == '0 && in_ready && !err_unknown)); // R1

  AST_RSVD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_method != '0 && in_method < METHOD_W'(RSVD_LIMIT))
      |-> (err_reserved && eng_valid == '0 && in_ready)); // R2

  AST_FWD_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_valid != '0) |-> (eng_method == in_method && eng_data == in_data
                           && in_method >= METHOD_W'(RSVD_LIMIT))); // R3

  AST_REM_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid[1] |-> (rem_3d == in_remain)); // R5

  AST_HIGH_RESOLVED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_method >= METHOD_W'(RSVD_LIMIT))
      |-> ((eng_valid != '0) != err_unknown)); // R6

  AST_UNKNOWN_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    err_unknown |-> in_ready); // R6

  AST_STALL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_valid != '0) |-> (in_ready == ((eng_valid & eng_ready) != '0))); // R8
endmodule

bind subch_router subch_router_chk #(
  .METHOD_W   (METHOD_W),
  .DATA_W     (DATA_W),
  .REM_W      (REM_W),
  .SUBCH_N    (SUBCH_N),
  .RSVD_LIMIT (RSVD_LIMIT)
) u_chk (.*);

// File: tb/subch_router_bench.sv
module subch_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [12:0] in_method = '0;
  logic [2:0]  in_subch = '0;
  logic [31:0] in_data = '0;
  logic [7:0]  in_remain = '0;
  logic [4:0]  eng_valid;
  logic [4:0]  eng_ready = 5'b11111;
  logic [12:0] eng_method;
  logic [31:0] eng_data;
  logic [7:0]  rem_3d;
  logic        err_reserved;
  logic        err_unknown;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  subch_router u_subch_router (.*);

  typedef struct packed {
    logic [12:0] method;
    logic [2:0]  subch;
    logic [31:0] data;
    logic [7:0]  rem;
    logic [4:0]  expv;
    logic        eres;
    logic        eunk;
  } vec_t;

  // Engine codes (R4): 1=2D bit0, 2=3D bit1, 3=compute bit2, 4=DMA bit3, 5=inline bit4
  localparam vec_t VECS [16] = '{
    '{13'h000, 3'd0, 32'h0000_0002, 8'd0,  5'b00000, 1'b0, 1'b0},
    '{13'h040, 3'd0, 32'hA000_0001, 8'd3,  5'b00010, 1'b0, 1'b0},
    '{13'h000, 3'd1, 32'h0000_0004, 8'd0,  5'b00000, 1'b0, 1'b0},
    '{13'h100, 3'd1, 32'hA000_0002, 8'd9,  5'b01000, 1'b0, 1'b0},
    '{13'h010, 3'd0, 32'hA000_0003, 8'd0,  5'b00000, 1'b1, 1'b0},
    '{13'h000, 3'd2, 32'h0000_0007, 8'd0,  5'b00000, 1'b0, 1'b0},
    '{13'h050, 3'd2, 32'hA000_0004, 8'd0,  5'b00000, 1'b0, 1'b1},
    '{13'h000, 3'd3, 32'h0000_0001, 8'd0,  5'b00000, 1'b0, 1'b0},
    '{13'h041, 3'd3, 32'hA000_0005, 8'd1,  5'b00001, 1'b0, 1'b0},
    '{13'h000, 3'd4, 32'h0000_0003, 8'd0,  5'b00000, 1'b0, 1'b0},
    '{13'h7FF, 3'd4, 32'hA000_0006, 8'd2,  5'b00100, 1'b0, 1'b0},
    '{13'h000, 3'd7, 32'h0000_0005, 8'd0,  5'b00000, 1'b0, 1'b0},
    '{13'h1FFF,3'd7, 32'hA000_0007, 8'd4,  5'b10000, 1'b0, 1'b0},
    '{13'h03F, 3'd7, 32'hA000_0008, 8'd0,  5'b00000, 1'b1, 1'b0},
    '{13'h001, 3'd5, 32'hA000_0009, 8'd0,  5'b00000, 1'b1, 1'b0},
    '{13'h040, 3'd5, 32'hA000_000A, 8'd0,  5'b00000, 1'b0, 1'b1}
  };

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string row_tag(input vec_t v);
    if (v.method == 13'h0) return "R1";
    if (v.eres)            return "R2";
    if (v.eunk)            return "R6";
    return "R3";
  endfunction

  task automatic drive(input logic [12:0] m, input logic [2:0] s,
                       input logic [31:0] d, input logic [7:0] r);
    @(negedge clk);
    in_valid  = 1'b1;
    in_method = m;
    in_subch  = s;
    in_data   = d;
    in_remain = r;
    #1;
  endtask

  task automatic check_outcome(input string tag, input logic [4:0] v,
                               input logic eres, input logic eunk);
    chk(tag, "eng_valid", 64'(eng_valid), 64'(v));
    chk(tag, "err_reserved", 64'(err_reserved), 64'(eres));
    chk(tag, "err_unknown", 64'(err_unknown), 64'(eunk));
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R7: reset state at the ports, then unbound subchannel reports unknown
    check_outcome("R7", 5'b0, 1'b0, 1'b0);
    chk("R7", "in_ready idle", 64'(in_ready), 64'd1);
    drive(13'h040, 3'd6, 32'h1234, 8'd0);
    check_outcome("R7", 5'b0, 1'b0, 1'b1);
    drive(13'h040, 3'd0, 32'h1234, 8'd0);
    check_outcome("R7", 5'b0, 1'b0, 1'b1);

    for (int i = 0; i < 16; i++) begin
      drive(VECS[i].method, VECS[i].subch, VECS[i].data, VECS[i].rem);
      check_outcome(row_tag(VECS[i]), VECS[i].expv, VECS[i].eres, VECS[i].eunk);
      chk(row_tag(VECS[i]), "in_ready", 64'(in_ready), 64'd1);
      if (VECS[i].expv != '0) begin
        chk("R3", "eng_method", 64'(eng_method), 64'(VECS[i].method));
        chk("R3", "eng_data", 64'(eng_data), 64'(VECS[i].data));
        chk("R5", "rem_3d", 64'(rem_3d), 64'(VECS[i].rem));
      end
    end

    // R10: subchannel 0 still bound to 3D after the other binds
    drive(13'h055, 3'd0, 32'hB000_0001, 8'd6);
    check_outcome("R10", 5'b00010, 1'b0, 1'b0);

    // R8: back-pressure follows the addressed port only
    eng_ready = 5'b11101;
    #1;
    chk("R8", "in_ready stalled", 64'(in_ready), 64'd0);
    chk("R8", "valid held without ready", 64'(eng_valid), 64'b00010);
    eng_ready = 5'b00010;
    #1;
    chk("R8", "in_ready released", 64'(in_ready), 64'd1);

    // R2: reserved method accepted with all readies low
    eng_ready = 5'b00000;
    drive(13'h020, 3'd0, 32'h0, 8'd0);
    check_outcome("R2", 5'b0, 1'b1, 1'b0);
    chk("R2", "in_ready no backpressure", 64'(in_ready), 64'd1);

    // R6: unknown target accepted with readies low; upper bits matter
    drive(13'h000, 3'd6, 32'h0000_0102, 8'd0);
    chk("R1", "bind in_ready", 64'(in_ready), 64'd1);
    drive(13'h040, 3'd6, 32'h0, 8'd0);
    check_outcome("R6", 5'b0, 1'b0, 1'b1);
    chk("R6", "in_ready", 64'(in_ready), 64'd1);
    eng_ready = 5'b11111;

    // R1: rebinding subchannel 0 to 2D takes effect on the next write
    drive(13'h000, 3'd0, 32'h0000_0001, 8'd0);
    check_outcome("R1", 5'b0, 1'b0, 1'b0);
    drive(13'h060, 3'd0, 32'hC0DE, 8'd0);
    check_outcome("R1", 5'b00001, 1'b0, 1'b0);
    // R10: subchannel 1 keeps DMA
    drive(13'h060, 3'd1, 32'hC0DF, 8'd0);
    check_outcome("R10", 5'b01000, 1'b0, 1'b0);

    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check_outcome("R9", 5'b0, 1'b0, 1'b0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule